// File: doc/BRIEF.md
# Per-Channel Delay-Mode Time-Slot Interchanger

This block reorders the bytes of a framed TDM stream. One byte enters per clock, and each clock is one time-slot. A frame holds 32, 64 or 128 slots, chosen by a rate input. For every output slot, a connection table names the input slot to copy and selects one of two timing modes for that channel. In variable mode the channel gets the lowest latency the slot spacing allows. In constant mode the channel always reads data written two frames earlier, so data that spans several slots stays together in one frame.

Input bytes are written into three frame-sized buffers that rotate at each frame boundary. An output slot reads the buffer that matches its mode and the distance between its source and destination slots. The connection table is double-banked. Writes go to a pending bank, and that bank is copied into the live bank at the end of the frame. Until the buffer a channel needs holds real data after reset, that channel outputs all-ones.

Top module: `tsi_switch`

## Requirements
- R1: `in_slot` starts at 0 after reset, counts up by one each clock, and wraps to 0 after slot L-1. L is 32 for `rate_sel`=0, 64 for `rate_sel`=1 and 128 for `rate_sel`=2.
- R2: The byte for output slot m appears on `out_byte` in the clock after `in_slot` equals m. At the same time `out_slot` equals m, and `out_fstart` is 1 exactly when m is 0.
- R3: A variable-mode entry (`cm_const`=0) with source n and destination m, where m ≥ n+3, outputs the byte from input slot n of the same frame.
- R4: A variable-mode entry with m ≤ n+2, which includes every m < n, outputs the byte from input slot n of the previous frame.
- R5: A constant-mode entry (`cm_const`=1) in frame k outputs the byte that entered at source slot n in frame k-2, for any n and m.
- R6: With L=32 in constant mode, source 31 to destination 0 spans one frame (32 slots). Source 0 to destination 31 spans 94 slots, measured from the end of the input slot to the start of the output slot.
- R7: A connection write (`cm_we`, `cm_addr`=m, `cm_src`, `cm_const`) made during frame k has no effect on the output in frame k and governs slot m from frame k+1 on.
- R8: `out_byte` is 0xFF whenever the buffer the entry needs has not been filled since reset. That means frame 0 for a previous-frame variable read, and frames 0 and 1 for a constant read.
- R9: During and after reset, `out_byte` is 0xFF and `in_slot`, `out_slot` and `out_fstart` are 0. Every entry starts in variable mode with source equal to its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Frame length select: 0=32, 1=64, 2=128 slots |
| in_byte | input | 8 | Byte of the current input slot |
| in_slot | output | 7 | Current input slot number |
| cm_we | input | 1 | Connection table write strobe |
| cm_addr | input | 7 | Destination slot being written |
| cm_src | input | 7 | Source slot for that destination |
| cm_const | input | 1 | 1 = constant mode, 0 = variable mode |
| out_byte | output | 8 | Switched output byte |
| out_slot | output | 7 | Slot number that out_byte belongs to |
| out_fstart | output | 1 | Marks output slot 0 |

## Verification
A buffer rotation that slips by one shows up within three frames: constant-mode slots return bytes one frame too new or too old, while same-frame variable slots may still look correct. An error in the three-slot threshold moves the byte by a whole frame only on destinations two or three slots after their source. An early map swap corrupts the slots written mid-frame within the same frame. The bench derives every expected byte from a per-slot pattern that differs in every frame, so each of these faults changes the value compared in the slot concerned.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;

    typedef enum logic [1:0] {
        RD_SAME  = 2'd0,
        RD_PREV  = 2'd1,
        RD_HOLD2 = 2'd2
    } rd_sel_e;

    // Slots per frame for each rate code.
    function automatic int unsigned frame_len(input logic [1:0] rate);
        case (rate)
            2'd0:    return 32;
            2'd1:    return 64;
            default: return 128;
        endcase
    endfunction

    // Step a three-way buffer index.
    function automatic logic [1:0] next3(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

endpackage

// File: rtl/tsi_timing.sv
`timescale 1ns/1ps
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    output logic [SLOT_W-1:0] slot_o,
    output logic [1:0]        buf_o,
    output logic [1:0]        fill_o,
    output logic              frame_end_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [1:0]        bufi;
        logic [1:0]        fill;
    } tim_st_t;

    tim_st_t st_d, st_q;
    logic [SLOT_W-1:0] last_slot;
    logic              frame_end;

    always_comb begin
        last_slot = SLOT_W'(frame_len(rate_sel) - 1);
        frame_end = (st_q.slot == last_slot);
        st_d      = st_q;
        if (frame_end) begin
            st_d.slot = '0;
            st_d.bufi = next3(st_q.bufi);
            if (st_q.fill != 2'd2) begin
                st_d.fill = st_q.fill + 2'd1;
            end
        end else begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o      = st_q.slot;
    assign buf_o       = st_q.bufi;
    assign fill_o      = st_q.fill;
    assign frame_end_o = frame_end;

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= last_slot);                                            // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> st_q.slot == '0);                                     // R1
    AST_BUF_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> st_q.bufi == next3($past(st_q.bufi)));                // R5
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.bufi));                                 // R5

endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem #(
    parameter int MAX_SLOTS = 128,
    parameter int SLOT_W    = $clog2(MAX_SLOTS),
    parameter int ENT_W     = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [SLOT_W-1:0] wr_src,
    input  logic              wr_const,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [SLOT_W-1:0] rd_src,
    output logic              rd_const
);

    typedef struct packed {
        logic [MAX_SLOTS-1:0][ENT_W-1:0] pend;
        logic [MAX_SLOTS-1:0][ENT_W-1:0] live;
    } map_st_t;

    map_st_t st_d, st_q;
    logic [ENT_W-1:0] rd_ent;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pend[wr_addr] = {wr_const, wr_src};
        end
        if (frame_end) begin
            st_d.live = st_d.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_SLOTS; i++) begin
                st_q.pend[i] <= {1'b0, SLOT_W'(i)};
                st_q.live[i] <= {1'b0, SLOT_W'(i)};
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ent   = st_q.live[rd_addr];
    assign rd_const = rd_ent[ENT_W-1];
    assign rd_src   = rd_ent[SLOT_W-1:0];

    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.live));                                 // R7

endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
    parameter int MAX_SLOTS = 128,
    parameter int DATA_W    = 8,
    parameter int NUM_BUFS  = 3,
    parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_buf,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_buf,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [NUM_BUFS][MAX_SLOTS];

    always_ff @(posedge clk) begin
        mem_q[wr_buf][wr_slot] <= wr_data;
    end

    assign rd_data = mem_q[rd_buf][rd_slot];

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf == wr_buf) |-> (rd_slot != wr_slot));                       // R3

endmodule

// File: rtl/tsi_switch.sv
`timescale 1ns/1ps
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int MAX_SLOTS = 128,
    parameter int DATA_W    = 8,
    parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic [DATA_W-1:0] in_byte,
    output logic [SLOT_W-1:0] in_slot,
    input  logic              cm_we,
    input  logic [SLOT_W-1:0] cm_addr,
    input  logic [SLOT_W-1:0] cm_src,
    input  logic              cm_const,
    output logic [DATA_W-1:0] out_byte,
    output logic [SLOT_W-1:0] out_slot,
    output logic              out_fstart
);

    localparam int GAP_MIN = 3;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic              fstart;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        wbuf;
    logic [1:0]        fill;
    logic              frame_end;
    logic [SLOT_W-1:0] src;
    logic              is_const;
    rd_sel_e           rsel;
    logic [1:0]        rbuf;
    logic              ready;
    logic [DATA_W-1:0] rdata;

    tsi_timing #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .slot_o      (slot),
        .buf_o       (wbuf),
        .fill_o      (fill),
        .frame_end_o (frame_end)
    );

    tsi_conn_mem #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_conn (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .wr_en     (cm_we),
        .wr_addr   (cm_addr),
        .wr_src    (cm_src),
        .wr_const  (cm_const),
        .rd_addr   (slot),
        .rd_src    (src),
        .rd_const  (is_const)
    );

    tsi_data_mem #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_buf  (wbuf),
        .wr_slot (slot),
        .wr_data (in_byte),
        .rd_buf  (rbuf),
        .rd_slot (src),
        .rd_data (rdata)
    );

    always_comb begin
        if (is_const) begin
            rsel = RD_HOLD2;
        end else if ({1'b0, slot} >= ({1'b0, src} + (SLOT_W+1)'(GAP_MIN))) begin
            rsel = RD_SAME;
        end else begin
            rsel = RD_PREV;
        end

        case (rsel)
            RD_SAME:  begin rbuf = wbuf;               ready = 1'b1;         end
            RD_PREV:  begin rbuf = next3(next3(wbuf)); ready = (fill != 2'd0); end
            default:  begin rbuf = next3(wbuf);        ready = (fill == 2'd2); end
        endcase

        st_d.data   = ready ? rdata : '1;
        st_d.slot   = slot;
        st_d.fstart = (slot == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data   <= '1;
            st_q.slot   <= '0;
            st_q.fstart <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_slot    = slot;
    assign out_byte   = st_q.data;
    assign out_slot   = st_q.slot;
    assign out_fstart = st_q.fstart;

    AST_OUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_slot == $past(slot));                                  // R2
    AST_CONST_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_const && fill != 2'd2) |=> out_byte == '1);                     // R8
    AST_PREV_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == RD_PREV && fill == 2'd0) |=> out_byte == '1);              // R8

endmodule

// File: tb/tsi_switch_bench.sv
`timescale 1ns/1ps
module tsi_switch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [7:0] in_byte = 8'h00;
    logic [6:0] in_slot;
    logic       cm_we = 1'b0;
    logic [6:0] cm_addr = '0;
    logic [6:0] cm_src = '0;
    logic       cm_const = 1'b0;
    logic [7:0] out_byte;
    logic [6:0] out_slot;
    logic       out_fstart;

    int n_checks = 0;
    int n_fail   = 0;

    int bf, bs, run, flen;
    int  act_src [128];
    bit  act_c   [128];
    int  pend_src[128];
    bit  pend_c  [128];

    logic [7:0] exp_byte_q[$];
    int         exp_slot_q[$];
    string      exp_tag_q[$];

    always #2.5 clk = ~clk;

    tsi_switch u_tsi_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .in_byte    (in_byte),
        .in_slot    (in_slot),
        .cm_we      (cm_we),
        .cm_addr    (cm_addr),
        .cm_src     (cm_src),
        .cm_const   (cm_const),
        .out_byte   (out_byte),
        .out_slot   (out_slot),
        .out_fstart (out_fstart)
    );

    function automatic logic [7:0] gen(int r, int f, int s);
        return 8'((f * 29 + s * 7 + r * 3 + 5) & 255);
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (frame %0d slot %0d)",
                     tag, what, act, exp, bf, bs);
        end
    endtask

    // Driver: drives one input slot, pushes the expected output, issues writes.
    task automatic drive_slot();
        int    n, m;
        bit    c;
        logic [7:0] e;
        string tag;
        check("R1", int'(in_slot), bs, "in_slot");
        in_byte = gen(run, bf, bs);
        m = bs;
        n = act_src[m];
        c = act_c[m];
        if (c) begin
            if (bf < 2) begin e = 8'hFF; tag = "R8"; end
            else begin
                e = gen(run, bf - 2, n);
                tag = (flen == 32 && ((n == 31 && m == 0) || (n == 0 && m == 31))) ? "R6" : "R5";
            end
        end else if (m >= n + 3) begin
            e = gen(run, bf, n); tag = "R3";
        end else if (bf < 1) begin
            e = 8'hFF; tag = "R8";
        end else begin
            e = gen(run, bf - 1, n);
            tag = (run == 2 && m != 63) ? "R9" : "R4";
        end
        if (run == 0 && m == 5 && (bf == 3 || bf == 4)) tag = "R7";
        exp_byte_q.push_back(e);
        exp_slot_q.push_back(m);
        exp_tag_q.push_back(tag);

        cm_we = 1'b0;
        case (1'b1)
            (run == 0 && bf == 0 && bs == 0): begin cm_we = 1; cm_addr = 0;   cm_src = 31; cm_const = 1; end
            (run == 0 && bf == 0 && bs == 1): begin cm_we = 1; cm_addr = 31;  cm_src = 0;  cm_const = 1; end
            (run == 0 && bf == 0 && bs == 2): begin cm_we = 1; cm_addr = 5;   cm_src = 2;  cm_const = 0; end
            (run == 0 && bf == 0 && bs == 3): begin cm_we = 1; cm_addr = 6;   cm_src = 4;  cm_const = 0; end
            (run == 0 && bf == 0 && bs == 4): begin cm_we = 1; cm_addr = 3;   cm_src = 10; cm_const = 0; end
            (run == 0 && bf == 0 && bs == 5): begin cm_we = 1; cm_addr = 8;   cm_src = 9;  cm_const = 1; end
            (run == 0 && bf == 3 && bs == 2): begin cm_we = 1; cm_addr = 5;   cm_src = 1;  cm_const = 1; end
            (run == 1 && bf == 0 && bs == 0): begin cm_we = 1; cm_addr = 127; cm_src = 0;  cm_const = 1; end
            (run == 1 && bf == 0 && bs == 1): begin cm_we = 1; cm_addr = 0;   cm_src = 127; cm_const = 0; end
            (run == 1 && bf == 0 && bs == 2): begin cm_we = 1; cm_addr = 100; cm_src = 20; cm_const = 0; end
            (run == 1 && bf == 0 && bs == 3): begin cm_we = 1; cm_addr = 50;  cm_src = 48; cm_const = 0; end
            (run == 2 && bf == 0 && bs == 0): begin cm_we = 1; cm_addr = 63;  cm_src = 60; cm_const = 0; end
            default: ;
        endcase
        if (cm_we) begin
            pend_src[cm_addr] = int'(cm_src);
            pend_c[cm_addr]   = cm_const;
        end
    endtask

    // Monitor: pops the oldest expected item and compares it with the outputs.
    task automatic monitor_slot();
        logic [7:0] e;
        int         s;
        string      tag;
        if (exp_byte_q.size() == 0) return;
        e   = exp_byte_q.pop_front();
        s   = exp_slot_q.pop_front();
        tag = exp_tag_q.pop_front();
        check(tag,  int'(out_byte), int'(e), "out_byte");
        check("R2", int'(out_slot), s, "out_slot");
        check("R2", int'(out_fstart), (s == 0) ? 1 : 0, "out_fstart");
    endtask

    task automatic run_case(int r, logic [1:0] rate, int frames);
        run = r;
        rate_sel = rate;
        flen = (rate == 0) ? 32 : (rate == 1) ? 64 : 128;
        rst_n = 1'b0;
        cm_we = 1'b0;
        for (int i = 0; i < 128; i++) begin
            act_src[i] = i; pend_src[i] = i; act_c[i] = 0; pend_c[i] = 0;
        end
        exp_byte_q.delete(); exp_slot_q.delete(); exp_tag_q.delete();
        repeat (3) @(negedge clk);
        check("R9", int'(out_byte), 8'hFF, "reset out_byte");
        check("R9", int'(in_slot), 0, "reset in_slot");
        check("R9", int'(out_slot), 0, "reset out_slot");
        check("R9", int'(out_fstart), 0, "reset out_fstart");
        rst_n = 1'b1;
        bf = 0; bs = 0;
        drive_slot();
        forever begin
            @(negedge clk);
            monitor_slot();
            bs++;
            if (bs == flen) begin
                bs = 0;
                bf++;
                for (int i = 0; i < 128; i++) begin
                    act_src[i] = pend_src[i]; act_c[i] = pend_c[i];
                end
            end
            if (bf == frames) break;
            drive_slot();
        end
        cm_we = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        run_case(0, 2'd0, 6);
        run_case(1, 2'd2, 4);
        run_case(2, 2'd1, 3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule